// File: doc/BRIEF.md
# Multi-Channel Serial ADC Scan Controller

This block sits on the host side of a four-wire serial link to an eight-input successive-approximation converter. It drives the active-low chip-select, makes a divided serial clock with a programmable half-period, and shifts out an 8-bit control word in each conversion to choose the next input. It also gathers the sixteen bits that come back in each conversion. While scanning it keeps chip-select low across back-to-back 16-clock conversions and visits the inputs whose enable bits are set, in ascending order.

The converter answers one conversion late: the word returned in a conversion belongs to the address sent in the conversion before it. The controller keeps that address as the tag of the result. It throws away the first conversion of every frame, because no address has been sent in that frame yet. Each 12-bit result goes out on a valid/ready port together with its channel number. When the consumer stalls, one more finished result is parked inside the block and the link is stopped cleanly, so nothing is lost.

Top module: `adc_scan_ctrl`

## Requirements
- R1: After reset and while idle, chip-select is high, the serial clock is high, the serial data output is 0 and no result is valid.
- R2: While chip-select is low, every high and low level of the serial clock lasts exactly H system clocks, where H is the half-period input, and a value of 0 is treated as 1. This includes the high level right after chip-select falls and the one just before it rises. Chip-select changes only while the serial clock is high and steady.
- R3: Each frame (chip-select low) contains a whole multiple of 16 rising serial-clock edges. While scanning continues, chip-select stays low from one conversion to the next, so one frame carries the whole scan.
- R4: In each conversion the controller sends an 8-bit control word, MSB first. Each bit changes after a falling edge and is sampled by the converter on one of the first 8 rising edges. Bits 5:3 of the word carry the address of the channel for the next conversion, the other five bits are 0, and the data line is 0 for rising edges 9 to 16.
- R5: Serial input is sampled on rising edges and assembled MSB first. The result is the low 12 bits of the 16-bit word, the first four bits received are ignored, and the value is passed on unchanged as straight binary.
- R6: Each result is tagged with the address sent in the previous conversion of the same frame. Address 0 means the first input and 7 means the eighth.
- R7: The first conversion of every frame is never delivered.
- R8: Enabled channels are visited in ascending order, wrapping from the highest back to the lowest. Disabled channels are skipped, and each frame starts at the lowest enabled channel.
- R9: When the run input is low or the enable mask is all zero, the current conversion is completed, chip-select is then raised, and no new frame starts.
- R10: While a result is valid and not yet accepted, its data and tag stay stable. If another result finishes while the output is still occupied, that result is kept internally, chip-select is raised after that conversion, and both results are delivered in order.
- R11: No frame starts while a result is parked internally. Once the parked result moves to the output, scanning resumes if it is still requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Scan request level |
| chan_en_i | input | 8 | One enable bit per input channel |
| half_per_i | input | HALF_W | Serial-clock half-period in system clocks |
| sdi_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low chip-select |
| sclk_o | output | 1 | Serial clock, idles high |
| sdo_o | output | 1 | Serial control data to the converter |
| res_valid_o | output | 1 | Result available |
| res_ready_i | input | 1 | Consumer accepts result |
| res_data_o | output | 12 | Conversion result |
| res_chan_o | output | 3 | Channel the result belongs to |

## Verification
The bench sweeps every non-zero enable mask with the fastest clock and a few masks at other half-periods, against a converter model that picks its channel from the control word it really received. A design that tagged results with the address sent in the same conversion would show the wrong channel on every result. One that delivered the first conversion of a frame would put stale data at the head of the stream. One that took the wrong 12 bits would mismatch the model's marker nibble. Emptying the mask in the middle of a scan checks that the frame still ends on a 16-edge boundary. Stalling the consumer checks that the link stops with one result parked, that neither result is lost or reordered, and that scanning restarts only after the parked result has been drained.

// File: rtl/adc_scan_pkg.sv
`timescale 1ns/1ps
package adc_scan_pkg;
  localparam int NCH      = 8;
  localparam int AW       = $clog2(NCH);
  localparam int WORD_W   = 16;
  localparam int RES_W    = 12;
  localparam int CTRL_W   = 8;
  localparam int ADDR_LSB = 3;

  typedef logic [AW-1:0] chan_t;
  typedef enum logic [1:0] {LK_IDLE, LK_LEAD, LK_XFER, LK_TAIL} link_st_e;

  // lowest set bit of the mask (0 when empty)
  function automatic chan_t lowest_chan(input logic [NCH-1:0] m);
    chan_t c;
    c = '0;
    for (int i = NCH-1; i >= 0; i--) if (m[i]) c = chan_t'(i);
    return c;
  endfunction

  // next enabled channel above cur, wrapping to the lowest
  function automatic chan_t next_chan(input logic [NCH-1:0] m, input chan_t cur);
    chan_t c;
    c = lowest_chan(m);
    for (int i = NCH-1; i >= 0; i--) if (m[i] && (i > int'(cur))) c = chan_t'(i);
    return c;
  endfunction

  function automatic logic [CTRL_W-1:0] ctrl_word(input chan_t a);
    logic [CTRL_W-1:0] w;
    w = '0;
    w[ADDR_LSB +: AW] = a;
    return w;
  endfunction
endpackage

// File: rtl/adc_link.sv
`timescale 1ns/1ps
module adc_link
  import adc_scan_pkg::*;
#(
  parameter int HALF_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cont_i,
  input  logic [HALF_W-1:0] half_i,
  input  chan_t            sel_i,
  input  logic             sdi_i,
  output logic             cs_n_o,
  output logic             sclk_o,
  output logic             sdo_o,
  output logic             idle_o,
  output logic             eoc_o,
  output logic [RES_W-1:0] word_o
);
  localparam int RC_W = $clog2(WORD_W) + 1;
  localparam int BS_W = $clog2(CTRL_W);

  link_st_e          st_q;
  logic [HALF_W-1:0] cnt_q, lim;
  logic [RC_W-1:0]   rc_q;
  logic [RES_W-2:0]  sh_q;
  logic [CTRL_W-1:0] cw;
  logic [BS_W-1:0]   bsel;
  logic              tick, rise, sdo_nx;

  assign lim    = (half_i == '0) ? '0 : half_i - HALF_W'(1);
  assign tick   = (cnt_q == lim);
  assign rise   = (st_q == LK_XFER) && tick && !sclk_o;
  assign eoc_o  = rise && (rc_q == RC_W'(WORD_W-1));
  assign word_o = {sh_q, sdi_i};
  assign idle_o = (st_q == LK_IDLE);
  assign cw     = ctrl_word(sel_i);
  assign bsel   = BS_W'(CTRL_W-1) - rc_q[BS_W-1:0];
  assign sdo_nx = (rc_q < RC_W'(CTRL_W)) ? cw[bsel] : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= LK_IDLE;
      cnt_q  <= '0;
      rc_q   <= '0;
      sh_q   <= '0;
      cs_n_o <= 1'b1;
      sclk_o <= 1'b1;
      sdo_o  <= 1'b0;
    end else begin
      case (st_q)
        LK_IDLE: if (start_i) begin
          st_q   <= LK_LEAD;
          cs_n_o <= 1'b0;
          cnt_q  <= '0;
          rc_q   <= '0;
        end
        LK_LEAD: if (tick) begin
          st_q   <= LK_XFER;
          cnt_q  <= '0;
          sclk_o <= 1'b0;
          sdo_o  <= sdo_nx;
        end else cnt_q <= cnt_q + HALF_W'(1);
        LK_XFER: if (tick) begin
          cnt_q <= '0;
          if (sclk_o) begin
            sclk_o <= 1'b0;
            sdo_o  <= sdo_nx;
          end else begin
            sclk_o <= 1'b1;
            sh_q   <= word_o[RES_W-2:0];
            if (eoc_o) begin
              rc_q <= '0;
              if (!cont_i) st_q <= LK_TAIL;
            end else rc_q <= rc_q + RC_W'(1);
          end
        end else cnt_q <= cnt_q + HALF_W'(1);
        LK_TAIL: if (tick) begin
          st_q   <= LK_IDLE;
          cs_n_o <= 1'b1;
          cnt_q  <= '0;
          sdo_o  <= 1'b0;
        end else cnt_q <= cnt_q + HALF_W'(1);
        default: st_q <= LK_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_chan_seq.sv
`timescale 1ns/1ps
module adc_chan_seq
  import adc_scan_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic           adv_i,
  input  logic [NCH-1:0] mask_i,
  output chan_t          sel_o,
  output chan_t          tag_o,
  output logic           first_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_o   <= '0;
      tag_o   <= '0;
      first_o <= 1'b1;
    end else if (start_i) begin
      sel_o   <= lowest_chan(mask_i);
      first_o <= 1'b1;
    end else if (adv_i) begin
      tag_o   <= sel_o;
      sel_o   <= next_chan(mask_i, sel_o);
      first_o <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_result_buf.sv
`timescale 1ns/1ps
module adc_result_buf
  import adc_scan_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [RES_W-1:0] data_i,
  input  chan_t            chan_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [RES_W-1:0] data_o,
  output chan_t            chan_o,
  output logic             hold_o,
  output logic             room_o
);
  logic [RES_W-1:0] hd_q;
  chan_t            hc_q;

  assign room_o = !valid_o || ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      chan_o  <= '0;
      hold_o  <= 1'b0;
      hd_q    <= '0;
      hc_q    <= '0;
    end else if (load_i) begin
      if (room_o) begin
        valid_o <= 1'b1;
        data_o  <= data_i;
        chan_o  <= chan_i;
      end else begin
        hold_o <= 1'b1;
        hd_q   <= data_i;
        hc_q   <= chan_i;
      end
    end else if (hold_o && room_o) begin
      valid_o <= 1'b1;
      data_o  <= hd_q;
      chan_o  <= hc_q;
      hold_o  <= 1'b0;
    end else if (valid_o && ready_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_scan_ctrl.sv
`timescale 1ns/1ps
module adc_scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic [NCH-1:0]    chan_en_i,
  input  logic [HALF_W-1:0] half_per_i,
  input  logic              sdi_i,
  output logic              cs_n_o,
  output logic              sclk_o,
  output logic              sdo_o,
  output logic              res_valid_o,
  input  logic              res_ready_i,
  output logic [RES_W-1:0]  res_data_o,
  output logic [AW-1:0]     res_chan_o
);
  // named internal events, also watched by the bound checker
  logic             idle_w, eoc_w, start_w, cont_w, adv_w, load_w;
  logic             first_w, hold_w, room_w, any_en_w;
  chan_t            sel_w, tag_w;
  logic [RES_W-1:0] word_w;

  assign any_en_w = |chan_en_i;
  assign start_w  = idle_w && run_i && any_en_w && !hold_w;
  assign load_w   = eoc_w && !first_w;
  assign cont_w   = run_i && any_en_w && !(load_w && !room_w);
  assign adv_w    = eoc_w && cont_w;

  adc_link #(.HALF_W(HALF_W)) u_link (
    .clk(clk), .rst_n(rst_n), .start_i(start_w), .cont_i(cont_w),
    .half_i(half_per_i), .sel_i(sel_w), .sdi_i(sdi_i),
    .cs_n_o(cs_n_o), .sclk_o(sclk_o), .sdo_o(sdo_o),
    .idle_o(idle_w), .eoc_o(eoc_w), .word_o(word_w)
  );

  adc_chan_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_w), .adv_i(adv_w),
    .mask_i(chan_en_i), .sel_o(sel_w), .tag_o(tag_w), .first_o(first_w)
  );

  adc_result_buf u_buf (
    .clk(clk), .rst_n(rst_n), .load_i(load_w), .data_i(word_w),
    .chan_i(tag_w), .ready_i(res_ready_i), .valid_o(res_valid_o),
    .data_o(res_data_o), .chan_o(res_chan_o), .hold_o(hold_w), .room_o(room_w)
  );
endmodule

// File: rtl/adc_scan_ctrl_chk.sv
`timescale 1ns/1ps
module adc_scan_ctrl_chk
  import adc_scan_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             sclk,
  input logic             run,
  input logic [NCH-1:0]   en,
  input logic             valid,
  input logic             ready,
  input logic [RES_W-1:0] data,
  input logic [AW-1:0]    chan,
  input logic             eoc,
  input logic             first,
  input logic             cont,
  input logic             hold
);
  // R2: chip-select moves only on a steady high serial clock
  a_r2_cs_on_high_sclk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cs_n) || $fell(cs_n)) |-> (sclk && $stable(sclk)));

  // R3: a continuing scan keeps chip-select low; a stopping one ends on a high clock
  a_r3_scan_keeps_cs_low: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc && cont) |=> !cs_n);
  a_r3_tail_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc && !cont) |=> (!cs_n && sclk));

  // R7: the first conversion of a frame does not produce a result
  a_r7_first_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc && first && !valid) |=> !valid);

  // R9: a frame starts only with run high and a non-empty mask
  a_r9_start_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> ($past(run) && $past(|en)));

  // R10: a pending result stays put until taken
  a_r10_pending_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(data) && $stable(chan)));

  // R11: no frame while a result is parked
  a_r11_no_start_while_parked: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> !$past(hold));
endmodule

bind adc_scan_ctrl adc_scan_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n_o), .sclk(sclk_o), .run(run_i),
  .en(chan_en_i), .valid(res_valid_o), .ready(res_ready_i), .data(res_data_o),
  .chan(res_chan_o), .eoc(eoc_w), .first(first_w), .cont(cont_w), .hold(hold_w)
);

// File: tb/adc_scan_ctrl_bench.sv
`timescale 1ns/1ps
module adc_scan_ctrl_bench;
  localparam int HW = 8;
  localparam int WD_LIMIT = 190000;

  logic clk = 1'b0, rst_n = 1'b0, run = 1'b0, ready = 1'b1, sdi = 1'b0;
  logic [7:0] en = '0;
  logic [HW-1:0] half = 8'd1;
  logic cs_n, sclk, sdo, valid;
  logic [11:0] data;
  logic [2:0] chan;

  int n_chk = 0, n_fail = 0, cyc = 0;

  adc_scan_ctrl #(.HALF_W(HW)) u_adc_scan_ctrl (
    .clk(clk), .rst_n(rst_n), .run_i(run), .chan_en_i(en), .half_per_i(half),
    .sdi_i(sdi), .cs_n_o(cs_n), .sclk_o(sclk), .sdo_o(sdo), .res_valid_o(valid),
    .res_ready_i(ready), .res_data_o(data), .res_chan_o(chan)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int half_eff();
    return (half == 0) ? 1 : int'(half);
  endfunction

  function automatic int next_en(input logic [7:0] m, input int last);
    for (int k = 1; k <= 8; k++) if (m[(last + k) % 8]) return (last + k) % 8;
    return -1;
  endfunction

  // converter model and monitor state
  bit prev_cs = 1'b1, prev_sclk = 1'b1, ord_on = 1'b0;
  int rc = 0, frame_rises = 0, conv_in_frame = 0, seq = 0, lvl_len = 0;
  int frames_started = 0, n_acc = 0, last_ch = 7, q_wr = 0, q_rd = 0, exp_ch = 0;
  logic [7:0] din_sr = '0;
  logic [2:0] m_addr = '0, cur_chan = '0;
  logic [15:0] cur_word = '0;
  logic [11:0] qd[64];
  logic [2:0] qc[64];

  task automatic start_conv();
    cur_chan = m_addr;
    cur_word = {4'b1010, m_addr, 9'(seq)};
    seq++;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_cs && !cs_n) begin
        check(sclk == 1'b1, "R2 chip-select fell with clock low", int'(sclk), 1);
        rc = 0; frame_rises = 0; conv_in_frame = 0; lvl_len = 1;
        frames_started++;
        start_conv();
        sdi <= cur_word[15];
      end else if (!cs_n) begin
        if (sclk != prev_sclk) begin
          check(lvl_len == half_eff(), "R2 clock level length", lvl_len, half_eff());
          lvl_len = 1;
          if (sclk) begin
            if (rc < 8) din_sr = {din_sr[6:0], sdo};
            else check(sdo == 1'b0, "R4 data line idle after control word", int'(sdo), 0);
            rc++; frame_rises++;
            if (rc == 8)
              check(din_sr[7:6] == 2'b00 && din_sr[2:0] == 3'b000,
                    "R4 spare control bits zero", int'(din_sr), int'(din_sr & 8'h38));
            if (rc == 16) begin
              if (conv_in_frame > 0) begin
                qd[q_wr % 64] = cur_word[11:0];
                qc[q_wr % 64] = cur_chan;
                q_wr++;
              end
              m_addr = din_sr[5:3];
              conv_in_frame++; rc = 0;
              start_conv();
            end
          end else begin
            sdi <= cur_word[15 - rc];
          end
        end else lvl_len++;
      end else if (!prev_cs && cs_n) begin
        check(lvl_len == half_eff() && prev_sclk, "R2 final high level", lvl_len, half_eff());
        check(frame_rises % 16 == 0, "R3 frame edge count", frame_rises, (frame_rises / 16) * 16);
      end
      if (valid && ready) begin
        n_acc++;
        if (q_rd == q_wr) check(1'b0, "R7 result with no pending conversion", int'(data), -1);
        else begin
          check(data == qd[q_rd % 64], "R5 R7 result data", int'(data), int'(qd[q_rd % 64]));
          check(chan == qc[q_rd % 64], "R6 result tag", int'(chan), int'(qc[q_rd % 64]));
          q_rd++;
        end
        if (ord_on) begin
          exp_ch = next_en(en, last_ch);
          check(int'(chan) == exp_ch, "R8 scan order", int'(chan), exp_ch);
        end
        last_ch = int'(chan);
      end
    end
    prev_cs = cs_n;
    prev_sclk = sclk;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD_LIMIT) begin
      check(1'b0, "watchdog expired", cyc, WD_LIMIT);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_high(input string req);
    int t = 0;
    while (cs_n !== 1'b1 && t < 5000) begin tick(1); t++; end
    check(cs_n === 1'b1, req, int'(cs_n), 1);
  endtask

  task automatic run_case(input logic [7:0] mask, input int n);
    int t = 0, base, f0;
    en = mask; last_ch = 7; ord_on = 1'b1; base = n_acc; f0 = frames_started;
    run = 1'b1;
    while (n_acc < base + n && t < 20000) begin tick(1); t++; end
    check(n_acc >= base + n, "R8 results delivered", n_acc - base, n);
    check(frames_started == f0 + 1, "R3 one frame per scan", frames_started - f0, 1);
    run = 1'b0;
    wait_high("R9 frame ends after run drops");
    tick(4);
    check(q_rd == q_wr, "R10 no result left behind", q_wr - q_rd, 0);
  endtask

  initial begin
    int f0, t;
    logic [11:0] d0;
    logic [2:0] c0;
    tick(2);
    check(cs_n && sclk && !sdo && !valid, "R1 reset state", int'({cs_n, sclk, sdo, valid}), 12);
    rst_n = 1'b1;
    tick(3);
    check(cs_n && sclk && !sdo && !valid, "R1 idle with run low", int'({cs_n, sclk, sdo, valid}), 12);

    half = 8'd1;
    for (int m = 1; m < 256; m++) run_case(8'(m), 5);
    half = 8'd2; run_case(8'hA5, 4);
    half = 8'd3; run_case(8'h42, 4);
    half = 8'd0; run_case(8'h81, 3);
    half = 8'd5; run_case(8'h3C, 4);

    // R9: empty mask
    half = 8'd1; ord_on = 1'b0; en = 8'h00; f0 = frames_started; run = 1'b1;
    tick(80);
    check(frames_started == f0 && cs_n, "R9 empty mask starts nothing", frames_started - f0, 0);
    en = 8'hFF;
    tick(150);
    en = 8'h00;
    wait_high("R9 cleared mask ends frame");
    f0 = frames_started;
    tick(60);
    check(frames_started == f0, "R9 no restart with empty mask", frames_started - f0, 0);
    run = 1'b0;
    tick(4);
    check(q_rd == q_wr, "R10 results after mask clear delivered", q_wr - q_rd, 0);

    // R10 / R11: back-pressure
    half = 8'd2; ready = 1'b0; en = 8'h0F; f0 = frames_started; run = 1'b1;
    t = 0;
    while (!valid && t < 2000) begin tick(1); t++; end
    d0 = data; c0 = chan;
    tick(400);
    check(cs_n == 1'b1, "R10 link stops when output full", int'(cs_n), 1);
    check(valid && data == d0 && chan == c0, "R10 pending result held", int'(data), int'(d0));
    check(frames_started == f0 + 1, "R11 no frame while parked", frames_started - f0, 1);
    check(q_wr - q_rd == 2, "R10 two results waiting", q_wr - q_rd, 2);
    ready = 1'b1;
    tick(300);
    check(frames_started == f0 + 2, "R11 scan resumes after drain", frames_started - f0, 2);
    run = 1'b0;
    wait_high("R9 frame ends after run drops");
    tick(4);
    check(q_rd == q_wr, "R10 nothing lost under back-pressure", q_wr - q_rd, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule